// File: doc/BRIEF.md
# SPI Daisy-Chain Peripheral Shifter

This block is the slave side of a clocked serial port for a register-programmed peripheral. A fast system clock samples the active-low select, the serial clock and the serial data input. Bits move into an internal shift register, most significant bit first. The word reaches the parallel output only when the select line returns high. The bit pushed out of the far end of the shift register is driven on the serial data output, so one device's output can feed the next device's input. A chain of N devices is then loaded in a single frame of N×WORD_W serial clocks.

The serial clock polarity and phase are fixed by the parameters CPOL and CPHA. Which serial clock edge captures data follows from CPOL xor CPHA: rising when it is 0, falling when it is 1. The other edge updates the output bit. The output enable is deasserted whenever the device is not selected, so the pad can be released. The system clock must run at least four times faster than the serial clock. Chained devices need about eight times, because each link adds one synchroniser delay.

Top module: `spi_chain_slave`

## Requirements
- R1: While reset is asserted and after it is released, `word_o` is all zeros, `load_o` and `frame_err_o` are 0, and `dout_oe_o` is 0.
- R2: For each of the four CPOL/CPHA settings, the idle serial clock level equals CPOL. DIN is captured on the rising edge when CPOL xor CPHA is 0, and on the falling edge when it is 1.
- R3: Bits are shifted in most significant first, so the first bit of a frame ends up in `word_o[WORD_W-1]`. `word_o` keeps its previous value for the whole time select is low, including after the last serial clock edge.
- R4: Each rise of select loads the current shift register contents into `word_o`. `load_o` is high for exactly one system clock in the cycle where `word_o` takes its new value.
- R5: The data output presents the shift register contents most significant bit first and moves one bit per serial clock. The output changes on the non-capturing edge, so a chain of N devices passes N×WORD_W bits end to end.
- R6: While select is high, serial clock edges do not change the shift register, the output bit or `word_o`, and `dout_oe_o` is 0. While select is low, `dout_oe_o` is 1.
- R7: If select rises after a number of capturing edges that is not a multiple of WORD_W, `word_o` still loads the shift register contents and `frame_err_o` pulses in the same cycle as `load_o`. A frame of a whole multiple of WORD_W edges, including zero, raises no error.
- R8: From the fall of select until the first output-updating edge, the data output holds the shift register's most significant bit. This makes the first bit valid before the first capturing edge when CPHA is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low select from the master |
| sclk_i | input | 1 | Serial clock from the master |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output (bit leaving the shift register) |
| dout_oe_o | output | 1 | Output enable for dout_o, high while selected |
| word_o | output | WORD_W | Parallel word committed at the end of a frame |
| load_o | output | 1 | One-cycle pulse when word_o is updated |
| frame_err_o | output | 1 | One-cycle pulse when the committed frame was not a whole number of words |

## Verification
The commit of the parallel word and the frame-length error must land in the same system clock cycle. The bench provokes this with short frames of 3 and 5 bits and a long frame of 12 bits through a two-device chain, in all four clock modes at once. For each frame it counts both pulses over a window after select rises and compares the committed words with a bit-level model of the chain. Serial clock toggling while select is high is also run against a later readback, to show the ignored edges left the shift registers untouched.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  // Per-cycle events decoded from the synchronised serial inputs.
  typedef struct packed {
    logic capture;   // edge that samples the data input
    logic launch;    // edge that updates the data output
    logic sel_start; // select has just fallen
    logic sel_end;   // select has just risen
  } spi_evt_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_edge_dec.sv
module spi_edge_dec
  import spi_chain_pkg::*;
#(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_s,
  input  logic     sclk_s,
  output spi_evt_t evt
);
  logic cs_p_q, sclk_p_q;
  logic sclk_rise, sclk_fall, cap_e, lau_e, sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p_q   <= 1'b1;
      sclk_p_q <= CPOL;
    end else begin
      cs_p_q   <= cs_s;
      sclk_p_q <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_p_q;
  assign sclk_fall = ~sclk_s & sclk_p_q;

  generate
    if ((CPOL ^ CPHA) == 1'b0) begin : g_cap_rise
      assign cap_e = sclk_rise;
      assign lau_e = sclk_fall;
    end else begin : g_cap_fall
      assign cap_e = sclk_fall;
      assign lau_e = sclk_rise;
    end
  endgenerate

  assign sel = ~cs_s;

  always_comb begin
    evt.capture   = sel & cap_e;
    evt.launch    = sel & lau_e;
    evt.sel_start = ~cs_s & cs_p_q;
    evt.sel_end   = cs_s & ~cs_p_q;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_chain_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_evt_t          evt,
  input  logic              din_s,
  output logic              dout,
  output logic [WORD_W-1:0] word,
  output logic              load,
  output logic              frame_err
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q, shreg_d, word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dout_q, dout_d, load_q, load_d, err_q, err_d;
  logic              shreg_en, cnt_en, dout_en, word_en;

  // next-state logic
  always_comb begin
    shreg_d = {shreg_q[WORD_W-2:0], din_s};
    cnt_d   = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    dout_d  = shreg_q[WORD_W-1];
    word_d  = shreg_q;
    load_d  = evt.sel_end;
    err_d   = evt.sel_end & (cnt_q != '0);
    if (evt.sel_start) cnt_d = '0;
    shreg_en = evt.capture & ~evt.sel_start;
    cnt_en   = evt.capture | evt.sel_start;
    dout_en  = evt.launch | evt.sel_start;
    word_en  = evt.sel_end;
  end

  // state registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      dout_q  <= 1'b0;
      word_q  <= '0;
      load_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (shreg_en) shreg_q <= shreg_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (dout_en)  dout_q  <= dout_d;
      if (word_en)  word_q  <= word_d;
      load_q <= load_d;
      err_q  <= err_d;
    end
  end

  assign dout      = dout_q;
  assign word      = word_q;
  assign load      = load_q;
  assign frame_err = err_q;
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter bit CPOL        = 1'b0,
  parameter bit CPHA        = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o,
  output logic              frame_err_o
);
  localparam logic [2:0] PIN_IDLE = {1'b1, CPOL, 1'b0};

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic [2:0] pins_s;
  spi_evt_t   evt;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({cs_n_i, sclk_i, din_i}),
    .q     (pins_s)
  );

  spi_edge_dec #(.CPOL(CPOL), .CPHA(CPHA)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cs_s   (pins_s[2]),
    .sclk_s (pins_s[1]),
    .evt    (evt)
  );

  spi_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt       (evt),
    .din_s     (pins_s[0]),
    .dout      (dout_o),
    .word      (word_o),
    .load      (load_o),
    .frame_err (frame_err_o)
  );

  assign dout_oe_o = ~pins_s[2];
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_i,
  input logic              dout_o,
  input logic              dout_oe_o,
  input logic [WORD_W-1:0] word_o,
  input logic              load_o,
  input logic              frame_err_o
);
  // R4
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R7
  err_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> load_o);

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |-> $stable(word_o));

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !dout_oe_o);

  // R6
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> $stable(dout_o));
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n_i      (cs_n_i),
  .dout_o      (dout_o),
  .dout_oe_o   (dout_oe_o),
  .word_o      (word_o),
  .load_o      (load_o),
  .frame_err_o (frame_err_o)
);

// File: tb/tb_spi_chain_slave.sv
`timescale 1ns/1ps
module tb_spi_chain_slave;
  localparam int W = 4;
  localparam int HALF = 8; // system clocks per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic din = 1'b0;
  logic act = 1'b0;
  logic ph = 1'b0;

  logic         sclk_m   [4];
  logic         link     [4];
  logic         link_oe  [4];
  logic         dout_end [4];
  logic         oe_end   [4];
  logic [W-1:0] w0 [4];
  logic [W-1:0] w1 [4];
  logic         ld0 [4];
  logic         ld1 [4];
  logic         er0 [4];
  logic         er1 [4];

  int total = 0;
  int fails = 0;
  logic [2*W-1:0] model = '0; // {tail device, head device} shift contents
  logic [2*W-1:0] cw = '0;    // committed words

  always #2.5 clk = ~clk;

  // mode m: CPOL = m[1], CPHA = m[0]; capture always at mid-bit
  for (genvar m = 0; m < 4; m++) begin : g_mode
    localparam bit CP = m[1];
    localparam bit PH = m[0];
    assign sclk_m[m] = CP ^ (act & (PH ? ~ph : ph));

    spi_chain_slave #(.WORD_W(W), .CPOL(CP), .CPHA(PH)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk_m[m]), .din_i(din),
      .dout_o(link[m]), .dout_oe_o(link_oe[m]), .word_o(w0[m]),
      .load_o(ld0[m]), .frame_err_o(er0[m]));

    spi_chain_slave #(.WORD_W(W), .CPOL(CP), .CPHA(PH)) dut_nxt (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk_m[m]), .din_i(link[m]),
      .dout_o(dout_end[m]), .dout_oe_o(oe_end[m]), .word_o(w1[m]),
      .load_o(ld1[m]), .frame_err_o(er1[m]));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int m,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s mode%0d: actual %0h expected %0h", tag, m, act_v, exp_v);
    end
  endtask

  task automatic frame(input int nb, input logic [15:0] bits);
    int  lc0 [4];
    int  lc1 [4];
    int  ec0 [4];
    int  ec1 [4];
    logic bv;
    logic experr;
    cs_n = 1'b0;
    tick(HALF);
    for (int b = 0; b < nb; b++) begin
      bv = bits[nb-1-b];
      din = bv; act = 1'b1; ph = 1'b0;
      tick(HALF);
      for (int m = 0; m < 4; m++) begin
        if (b == 0) begin
          // R8 first bit valid before any output-updating edge
          chk(dout_end[m] === model[2*W-1], "R8 first bit", m, dout_end[m], model[2*W-1]);
          // R6 enable high while selected
          chk(oe_end[m] === 1'b1, "R6 oe selected", m, oe_end[m], 1);
        end else begin
          // R5 chain output one bit per serial clock
          chk(dout_end[m] === model[2*W-1], "R5 chain out", m, dout_end[m], model[2*W-1]);
        end
      end
      model = {model[2*W-2:0], bv};
      ph = 1'b1;
      tick(HALF);
    end
    act = 1'b0; ph = 1'b0;
    tick(HALF);
    for (int m = 0; m < 4; m++)
      // R3 no commit before select rises
      chk({w1[m], w0[m]} === cw, "R3 hold", m, {w1[m], w0[m]}, cw);
    cs_n = 1'b1;
    for (int m = 0; m < 4; m++) begin lc0[m] = 0; lc1[m] = 0; ec0[m] = 0; ec1[m] = 0; end
    for (int t = 0; t < 12; t++) begin
      tick(1);
      for (int m = 0; m < 4; m++) begin
        lc0[m] += int'(ld0[m]); lc1[m] += int'(ld1[m]);
        ec0[m] += int'(er0[m] & ld0[m]); ec1[m] += int'(er1[m] & ld1[m]);
      end
    end
    cw = model;
    experr = (nb % W) != 0;
    for (int m = 0; m < 4; m++) begin
      // R2 R3 committed words, MSB first, per clock mode
      chk({w1[m], w0[m]} === cw, "R2 word", m, {w1[m], w0[m]}, cw);
      // R4 one load pulse per commit
      chk(lc0[m] == 1 && lc1[m] == 1, "R4 load", m, lc0[m] * 16 + lc1[m], 17);
      // R7 error pulse together with load
      chk(ec0[m] == int'(experr) && ec1[m] == int'(experr), "R7 frame err", m,
          ec0[m] * 16 + ec1[m], experr ? 17 : 0);
    end
  endtask

  task automatic idle_burst(input int nbits);
    int lc [4];
    for (int m = 0; m < 4; m++) lc[m] = 0;
    cs_n = 1'b1;
    for (int b = 0; b < nbits; b++) begin
      din = b[0]; act = 1'b1;
      for (int h = 0; h < 2; h++) begin
        ph = h[0];
        for (int t = 0; t < HALF; t++) begin
          tick(1);
          for (int m = 0; m < 4; m++) lc[m] += int'(ld0[m]) + int'(ld1[m]);
        end
        for (int m = 0; m < 4; m++)
          // R6 enable released while deselected
          chk(oe_end[m] === 1'b0 && link_oe[m] === 1'b0, "R6 oe idle", m, oe_end[m], 0);
      end
    end
    act = 1'b0; ph = 1'b0;
    tick(HALF);
    for (int m = 0; m < 4; m++) begin
      // R6 ignored edges leave the words and loads alone
      chk(lc[m] == 0, "R6 no load", m, lc[m], 0);
      chk({w1[m], w0[m]} === cw, "R6 word kept", m, {w1[m], w0[m]}, cw);
    end
  endtask

  initial begin
    tick(3);
    for (int m = 0; m < 4; m++)
      // R1 values while reset is held
      chk(w0[m] === '0 && ld0[m] === 1'b0 && er0[m] === 1'b0 && oe_end[m] === 1'b0,
          "R1 in reset", m, {w0[m], ld0[m], er0[m], oe_end[m]}, 0);
    rst_n = 1'b1;
    tick(6);
    for (int m = 0; m < 4; m++)
      // R1 values after reset release
      chk(w1[m] === '0 && ld1[m] === 1'b0 && er1[m] === 1'b0 && oe_end[m] === 1'b0,
          "R1 after reset", m, {w1[m], ld1[m], er1[m], oe_end[m]}, 0);
    frame(5, 16'h0015);         // R7 short frame
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        frame(2 * W, 16'((a << W) | b));
    idle_burst(10);             // R6
    frame(3, 16'h0005);         // R7
    frame(12, 16'h0A5C);        // R7 whole multiple, longer than chain
    frame(0, 16'h0000);         // R7 zero edges
    frame(2 * W, 16'h00C3);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule